// File: doc/BRIEF.md
# Edge-Interrupt GPIO Expander Core

This block is a register-mapped bank of general-purpose I/O lines. Lines are grouped eight to a bank, and the default build has three banks, which gives 24 lines. A host reaches every register through a simple synchronous port with a write strobe, an address, write data and combinational read data.

Each line has the following:
- a direction bit;
- an output latch, changed only through write-one-to-set and write-one-to-clear addresses;
- a readable, synchronised pin level;
- independent rising-edge and falling-edge enables;
- an interrupt enable.

An enabled edge on a line latches a sticky bit in two places: an edge-detect register and an interrupt-status register. Both are cleared by writing ones. The single active-high interrupt output is asserted while any status bit is pending whose interrupt enable is set.

The address is split into a register kind in the upper four bits and a bank slot in the low bits. Banks sit at descending slots. The slot of bank b is NBANK-1-b, so the most significant bank comes first, and a host reading consecutive addresses walks from the top bank down to bank 0.

Top module: `gpx_top`

## Requirements
- R1: Line n belongs to bank n/8 at bit n%8. The address is {kind[3:0], slot[1:0]}, and bank b is at slot NBANK-1-b, so bank 0 is at slot 2 and bank 2 is at slot 0 in the default build. The kind codes are:
  - 0: pin level
  - 1: direction
  - 2: set
  - 3: clear
  - 4: rising enable
  - 5: falling enable
  - 6: interrupt enable
  - 7: edge detect
  - 8: interrupt status
- R2: Writing to the set kind drives high every line whose written bit is 1 and leaves all other lines unchanged. Reading the set or the clear kind returns the output latch.
- R3: Writing to the clear kind drives low every line whose written bit is 1 and leaves all other lines unchanged.
- R4: A direction bit of 1 makes the line an output (`pin_oe_o` high) and 0 makes it an input. `pin_oe_o` changes only on a direction write.
- R5: The pin-level kind returns the level of `pin_i` after a two-flop synchroniser, whatever the line's direction. A change is visible two clock edges after it occurs.
- R6: A 0-to-1 transition of the synchronised level with the rising enable set, or a 1-to-0 transition with the falling enable set, sets the line's bit in both the edge-detect and the status register on the third clock edge after the pin change. With both enables set, both directions are caught. With neither set, nothing is latched.
- R7: A write to the edge-detect or status kind clears exactly the bits written as 1. Bits written as 0 keep their value, and bits are otherwise sticky.
- R8: When an enabled edge reaches a bit in the same cycle as a write-one-to-clear of that bit, the bit remains set.
- R9: `irq_o` is high exactly when some line has both its status bit and its interrupt-enable bit set.
- R10: After reset, every register reads 0, and `pin_o`, `pin_oe_o` and `irq_o` are low.
- R11: Reads of an unused slot or an unused kind (9 to 15) return 0. Writes to the pin-level kind, to an unused slot or to an unused kind change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 6 | Register address {kind, slot} |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| pin_i | input | 24 | Pad input levels |
| pin_o | output | 24 | Output latch values |
| pin_oe_o | output | 24 | Output enables (direction bits) |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest situation to reach from the ports is a pin edge that lands in a status bit in exactly the cycle in which the host clears that same bit.

The bench gets there by counting the synchroniser latency. It moves the pin on a falling clock edge and holds the clear write so that it commits on the third rising edge. Across the random phase, pin changes, direction changes and set/clear writes on loopback lines keep creating edges against a mix of enable settings. The expected status is recomputed from the old and new effective level of each line.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int BANK_W = 8;
  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    K_LVL  = 4'd0,
    K_DIR  = 4'd1,
    K_SET  = 4'd2,
    K_CLR  = 4'd3,
    K_RISE = 4'd4,
    K_FALL = 4'd5,
    K_IEN  = 4'd6,
    K_EDGE = 4'd7,
    K_STAT = 4'd8
  } kind_e;
endpackage

// File: rtl/gpx_rstsync.sv
module gpx_rstsync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/gpx_insync.sv
module gpx_insync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
  import gpx_pkg::*;
#(
  parameter int W = BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      rise_i,
  input  logic [W-1:0]      fall_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      re_o,
  output logic [W-1:0]      fe_o,
  output logic [W-1:0]      ie_o,
  output logic [W-1:0]      edge_o,
  output logic [W-1:0]      stat_o
);
  logic [W-1:0] dir_q, out_q, re_q, fe_q, ie_q, edge_q, stat_q;
  logic [W-1:0] dir_d, out_d, re_d, fe_d, ie_d, edge_d, stat_d;
  logic [W-1:0] ev, clr_edge, clr_stat;
  logic         cfg_en;

  always_comb begin
    ev       = (rise_i & re_q) | (fall_i & fe_q);
    clr_edge = (wr_i && kind_i == K_EDGE) ? wdata_i : '0;
    clr_stat = (wr_i && kind_i == K_STAT) ? wdata_i : '0;
    edge_d   = (edge_q & ~clr_edge) | ev;
    stat_d   = (stat_q & ~clr_stat) | ev;
    cfg_en   = wr_i;
    dir_d    = dir_q;
    out_d    = out_q;
    re_d     = re_q;
    fe_d     = fe_q;
    ie_d     = ie_q;
    case (kind_i)
      K_DIR:   dir_d = wdata_i;
      K_SET:   out_d = out_q | wdata_i;
      K_CLR:   out_d = out_q & ~wdata_i;
      K_RISE:  re_d  = wdata_i;
      K_FALL:  fe_d  = wdata_i;
      K_IEN:   ie_d  = wdata_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      re_q   <= '0;
      fe_q   <= '0;
      ie_q   <= '0;
      edge_q <= '0;
      stat_q <= '0;
    end else begin
      if (cfg_en) begin
        dir_q <= dir_d;
        out_q <= out_d;
        re_q  <= re_d;
        fe_q  <= fe_d;
        ie_q  <= ie_d;
      end
      edge_q <= edge_d;
      stat_q <= stat_d;
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign re_o   = re_q;
  assign fe_o   = fe_q;
  assign ie_o   = ie_q;
  assign edge_o = edge_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/gpx_top.sv
module gpx_top
  import gpx_pkg::*;
#(
  parameter int  NBANK  = 3,
  localparam int SLOT_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int ADDR_W = KIND_W + SLOT_W,
  localparam int NLINE  = NBANK * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [NLINE-1:0]  pin_i,
  output logic [NLINE-1:0]  pin_o,
  output logic [NLINE-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic              rst_sync_n;
  logic [KIND_W-1:0] kind;
  logic [SLOT_W-1:0] slot;
  logic              slot_ok;
  logic [NLINE-1:0]  lvl_all, rise_all, fall_all;
  logic [NLINE-1:0]  dir_all, out_all, re_all, fe_all, ie_all, edge_all, stat_all;

  gpx_rstsync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  gpx_insync #(.W(NLINE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .pin_i  (pin_i),
    .lvl_o  (lvl_all),
    .rise_o (rise_all),
    .fall_o (fall_all)
  );

  assign kind    = addr_i[ADDR_W-1 -: KIND_W];
  assign slot    = addr_i[SLOT_W-1:0];
  assign slot_ok = (int'(slot) < NBANK);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(NBANK - 1 - b);
    logic bank_wr;
    assign bank_wr = wr_en_i && (slot == MY_SLOT);

    gpx_bank #(.W(BANK_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .wr_i    (bank_wr),
      .kind_i  (kind),
      .wdata_i (wdata_i),
      .rise_i  (rise_all[b*BANK_W +: BANK_W]),
      .fall_i  (fall_all[b*BANK_W +: BANK_W]),
      .dir_o   (dir_all[b*BANK_W +: BANK_W]),
      .out_o   (out_all[b*BANK_W +: BANK_W]),
      .re_o    (re_all[b*BANK_W +: BANK_W]),
      .fe_o    (fe_all[b*BANK_W +: BANK_W]),
      .ie_o    (ie_all[b*BANK_W +: BANK_W]),
      .edge_o  (edge_all[b*BANK_W +: BANK_W]),
      .stat_o  (stat_all[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (slot_ok) begin
      for (int b = 0; b < NBANK; b++) begin
        if (slot == SLOT_W'(NBANK - 1 - b)) begin
          case (kind)
            K_LVL:        rdata_o = lvl_all[b*BANK_W +: BANK_W];
            K_DIR:        rdata_o = dir_all[b*BANK_W +: BANK_W];
            K_SET, K_CLR: rdata_o = out_all[b*BANK_W +: BANK_W];
            K_RISE:       rdata_o = re_all[b*BANK_W +: BANK_W];
            K_FALL:       rdata_o = fe_all[b*BANK_W +: BANK_W];
            K_IEN:        rdata_o = ie_all[b*BANK_W +: BANK_W];
            K_EDGE:       rdata_o = edge_all[b*BANK_W +: BANK_W];
            K_STAT:       rdata_o = stat_all[b*BANK_W +: BANK_W];
            default:      rdata_o = '0;
          endcase
        end
      end
    end
  end

  assign pin_o    = out_all;
  assign pin_oe_o = dir_all;
  assign irq_o    = |(stat_all & ie_all);
endmodule

// File: rtl/gpx_chk.sv
module gpx_chk
  import gpx_pkg::*;
#(
  parameter int  NBANK  = 3,
  localparam int SLOT_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int ADDR_W = KIND_W + SLOT_W,
  localparam int NLINE  = NBANK * BANK_W
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BANK_W-1:0] wdata_i,
  input logic [NLINE-1:0]  pin_o,
  input logic [NLINE-1:0]  pin_oe_o,
  input logic              irq_o,
  input logic [NLINE-1:0]  stat_all,
  input logic [NLINE-1:0]  re_all,
  input logic [NLINE-1:0]  fe_all
);
  logic [KIND_W-1:0] kind;
  logic [SLOT_W-1:0] slot;
  logic [NLINE-1:0]  wmask;

  assign kind = addr_i[ADDR_W-1 -: KIND_W];
  assign slot = addr_i[SLOT_W-1:0];

  always_comb begin
    wmask = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (slot == SLOT_W'(NBANK - 1 - b)) wmask[b*BANK_W +: BANK_W] = wdata_i;
    end
  end

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && kind == K_SET) |=> ((pin_o & $past(wmask)) == $past(wmask))); // R2
  AST_SET_KEEPS_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && kind == K_SET) |=> (((pin_o ^ $past(pin_o)) & ~$past(wmask)) == '0)); // R2
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && kind == K_CLR) |=> ((pin_o & $past(wmask)) == '0)); // R3
  AST_OE_ON_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pin_oe_o != $past(pin_oe_o)) |-> $past(wr_en_i && kind == K_DIR)); // R4
  AST_STAT_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((stat_all & ~$past(stat_all)) != '0) |-> ($past(re_all | fe_all) != '0)); // R6
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((~stat_all & $past(stat_all)) != '0) |-> $past(wr_en_i && kind == K_STAT)); // R7
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (stat_all != '0)); // R9
endmodule

bind gpx_top gpx_chk #(.NBANK(NBANK)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_sync_n),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .irq_o    (irq_o),
  .stat_all (stat_all),
  .re_all   (re_all),
  .fe_all   (fe_all)
);

// File: tb/gpx_top_tb.sv
module gpx_top_tb;
  localparam int NB = 3;
  localparam int NL = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [5:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [NL-1:0] pin_in, pin_out, pin_oe, ext;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [NL-1:0] m_dir, m_out, m_re, m_fe, m_ie, m_edge, m_stat;

  always #4 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpx_top #(.NBANK(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  function automatic logic [5:0] addr_of(int k, int b);
    return {4'(k), 2'(NB - 1 - b)};
  endfunction

  function automatic logic [NL-1:0] eff_level();
    return (m_dir & m_out) | (~m_dir & ext);
  endfunction

  function automatic logic [7:0] model_read(int k, int b);
    logic [NL-1:0] v;
    case (k)
      0: v = eff_level();
      1: v = m_dir;
      2, 3: v = m_out;
      4: v = m_re;
      5: v = m_fe;
      6: v = m_ie;
      7: v = m_edge;
      8: v = m_stat;
      default: v = '0;
    endcase
    return v[b*8 +: 8];
  endfunction

  function automatic string tag_of(int k);
    case (k)
      0: return "R5";
      1: return "R4";
      2: return "R2";
      3: return "R3";
      4, 5: return "R6";
      6: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic model_write(int k, int b, logic [7:0] d);
    logic [NL-1:0] m;
    m = '0;
    m[b*8 +: 8] = d;
    case (k)
      1: m_dir = (m_dir & ~({{(NL-8){1'b0}}, 8'hFF} << (b*8))) | m;
      2: m_out = m_out | m;
      3: m_out = m_out & ~m;
      4: m_re = (m_re & ~({{(NL-8){1'b0}}, 8'hFF} << (b*8))) | m;
      5: m_fe = (m_fe & ~({{(NL-8){1'b0}}, 8'hFF} << (b*8))) | m;
      6: m_ie = (m_ie & ~({{(NL-8){1'b0}}, 8'hFF} << (b*8))) | m;
      7: m_edge = m_edge & ~m;
      8: m_stat = m_stat & ~m;
      default: ;
    endcase
  endtask

  task automatic apply_events(logic [NL-1:0] old_l, logic [NL-1:0] new_l);
    logic [NL-1:0] ev;
    ev = (~old_l & new_l & m_re) | (old_l & ~new_l & m_fe);
    m_stat = m_stat | ev;
    m_edge = m_edge | ev;
  endtask

  task automatic do_write(int k, int b, logic [7:0] d);
    logic [NL-1:0] old_l;
    old_l = eff_level();
    bus_write(addr_of(k, b), d);
    model_write(k, b, d);
    settle();
    apply_events(old_l, eff_level());
  endtask

  task automatic do_pins(logic [NL-1:0] v);
    logic [NL-1:0] old_l;
    old_l = eff_level();
    @(negedge clk);
    ext = v;
    settle();
    apply_events(old_l, eff_level());
  endtask

  task automatic verify_all();
    logic [7:0] d;
    for (int k = 0; k < 9; k++) begin
      for (int b = 0; b < NB; b++) begin
        bus_read(addr_of(k, b), d);
        check(tag_of(k), 32'(d), 32'(model_read(k, b)));
      end
    end
    check("R9 irq", 32'(irq), 32'(|(m_stat & m_ie)));
    check("R2 pin_o", 32'(pin_out), 32'(m_out));
    check("R4 pin_oe", 32'(pin_oe), 32'(m_dir));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    ext = '0;
    {m_dir, m_out, m_re, m_fe, m_ie, m_edge, m_stat} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 irq", 32'(irq), 32'd0);
    check("R10 pin_oe", 32'(pin_oe), 32'd0);
    verify_all();

    // R1 bank placement: bank 0 at slot 2, bank 2 at slot 0
    do_write(2, 0, 8'h01);
    check("R1 line0", 32'(pin_out[0]), 32'd1);
    do_write(2, 2, 8'h80);
    check("R1 line23", 32'(pin_out[23]), 32'd1);
    do_write(1, 1, 8'h02);
    check("R1 line9 oe", 32'(pin_oe[9]), 32'd1);
    verify_all();

    // R5 level of an output line follows its latch; R6 both edges
    do_write(4, 1, 8'h02);
    do_write(5, 1, 8'h02);
    do_write(2, 1, 8'h02);
    bus_read(addr_of(8, 1), d);
    check("R6 rise on output", 32'(d[1]), 32'd1);
    do_write(8, 1, 8'h02);
    do_write(3, 1, 8'h02);
    bus_read(addr_of(8, 1), d);
    check("R6 fall on output", 32'(d[1]), 32'd1);
    verify_all();

    // R7 partial clear and R9 enable gating
    do_write(4, 0, 8'hFF);
    do_pins(24'h0000F0);
    do_write(8, 0, 8'h30);
    bus_read(addr_of(8, 0), d);
    check("R7 partial clear", 32'(d), 32'h000000C0);
    check("R9 irq masked", 32'(irq), 32'd0);
    do_write(6, 0, 8'h80);
    check("R9 irq enabled", 32'(irq), 32'd1);
    verify_all();

    // R8 edge coincides with clear of the same bit
    do_write(8, 0, 8'hFF);
    do_write(7, 0, 8'hFF);
    @(negedge clk);
    ext[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = addr_of(8, 0); wdata = 8'h08;
    @(negedge clk);
    wr_en = 1'b0;
    settle();
    m_stat[3] = 1'b1;
    m_edge[3] = 1'b1;
    bus_read(addr_of(8, 0), d);
    check("R8 event beats clear", 32'(d[3]), 32'd1);
    verify_all();

    // R11 unused addresses
    bus_read({4'd1, 2'd3}, d);
    check("R11 unused slot", 32'(d), 32'd0);
    bus_read({4'd12, 2'd0}, d);
    check("R11 unused kind", 32'(d), 32'd0);
    do_write(0, 0, 8'hFF);
    bus_write({4'd12, 2'd1}, 8'hFF);
    bus_write({4'd2, 2'd3}, 8'hFF);
    settle();
    verify_all();

    // random phase
    for (int i = 0; i < 250; i++) begin
      int op;
      int b;
      logic [7:0] v;
      op = $urandom_range(0, 9);
      b  = $urandom_range(0, NB - 1);
      v  = 8'($urandom);
      if (op == 0 || op == 9) do_pins(NL'($urandom));
      else do_write(op, b, v);
      verify_all();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule